// File: doc/BRIEF.md
# ATA Task-File Register Bank

This block sits on the device side of a parallel ATA link and holds the task file that a host programs through byte-wide port accesses. A 3-bit offset together with a control-block select reaches eight command-block locations and one control-block location. The parameter registers are the sector count, the three address bytes, features and the device/head byte. Some offsets decode differently for reads and writes. At offset 1 a read returns the error code and a write loads features. At offset 7 a read returns status and a write issues a command. Offset 0 is a 16-bit word port that hands words to and from a sector buffer outside this block.

An accepted command raises BSY and gives a one-cycle strobe, with the opcode and the parameters, to a device-side engine. When the engine reports completion, the block loads the status and error fields and raises a pending interrupt. The interrupt pin shows that flag unless the host has masked it. Reading Status acknowledges the interrupt. Reading the control-block status copy leaves it pending. Writing the control-block byte can hold the device in soft reset. After the soft reset is released, the device stays busy for a fixed recovery time and then reports ready.

Top module: `ata_taskfile`

## Requirements
- R1: After reset the status byte reads 0x40 (only DRDY set), the error byte reads 0x00, intrq is 0 and cmd_strobe is 0. Status bits are BSY=7, DRDY=6, DF=5, DRQ=3, ERR=0, and the other bits read 0.
- R2: Bytes written at command offsets 2, 3, 4 and 5 (count, address bits 7..0, 15..8, 23..16) read back unchanged. They also appear on tf_count and tf_lba.
- R3: The device byte at offset 6 always reads with bits 7 and 5 set to 1. Its bit 6 drives tf_lba_mode, its bit 4 drives tf_dev_sel, and its bits 3..0 form tf_lba[27:24].
- R4: A write at offset 1 loads tf_features. A read at offset 1 returns the error byte and is not affected by that write.
- R5: A write at offset 7 while BSY is 0 latches the byte on cmd_code and sets BSY. cmd_strobe is 1 for exactly the cycle after the write edge.
- R6: A write at offset 7 while BSY is 1, including during soft reset and its recovery, changes neither cmd_code nor cmd_strobe.
- R7: An eng_done pulse while a command is busy clears BSY. It copies eng_drq into DRQ and eng_df into DF, and it sets the pending interrupt.
- R8: A read at offset 7 returns status and clears the pending interrupt. A read of the control-block status copy (control select, offset 6) returns the same byte and leaves the pending interrupt set.
- R9: intrq equals the pending interrupt ANDed with the inverse of the mask bit (bit 1 of the control-block byte).
- R10: At completion eng_err_code is loaded into the error byte. ERR in status is 1 exactly when that code is nonzero.
- R11: Writing the control-block byte with bit 2 set forces BSY=1 and DRDY=0. It also clears DRQ, DF, ERR, the error byte and the pending interrupt.
- R12: After bit 2 is written back to 0, BSY stays 1 for RST_CYCLES cycles. It then drops to 0 while DRDY rises to 1, and commands are accepted again.
- R13: A write at offset 0 shows host_wword on word_out with word_push high in that cycle. A read at offset 0 pulses word_pop and registers word_in onto host_rword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register offset |
| host_ctl_sel | input | 1 | 1 selects the control block |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Byte write data |
| host_wword | input | 16 | Word write data for offset 0 |
| host_rdata | output | 8 | Registered byte read data |
| host_rword | output | 16 | Registered word read data for offset 0 |
| intrq | output | 1 | Interrupt request |
| cmd_strobe | output | 1 | One-cycle new-command pulse to the engine |
| cmd_code | output | 8 | Latched command opcode |
| tf_features | output | 8 | Features byte |
| tf_count | output | 8 | Sector count |
| tf_lba | output | 28 | Logical block address |
| tf_lba_mode | output | 1 | Addressing mode bit from the device byte |
| tf_dev_sel | output | 1 | Drive select from the device byte |
| word_push | output | 1 | A host word write is present |
| word_out | output | 16 | Word written by the host |
| word_pop | output | 1 | The host reads a word |
| word_in | input | 16 | Word offered by the sector buffer |
| eng_done | input | 1 | Engine completion pulse |
| eng_drq | input | 1 | DRQ value to report at completion |
| eng_df | input | 1 | Device-fault value to report at completion |
| eng_err_code | input | 8 | Error byte to report at completion |

## Verification
The bench attacks the places where a read and a write to one offset must stay apart. A write at offset 1 must not show up as the error byte. Reading the control-block status copy must not acknowledge the interrupt, while reading Status must. A bank that shared storage across those offsets, or cleared the interrupt on both reads, would return the features byte or lose the interrupt. The bench also issues a command while the device is busy and while it is held in soft reset. A design that missed either guard would pulse the strobe or overwrite the opcode. It then samples status one cycle before and one cycle after the recovery window ends, which catches an off-by-one in the recovery counter. Finally it toggles the mask bit while an interrupt is pending, so a pin that ignored the mask or lost the pending flag is caught.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  // command-block offsets whose meaning is fixed by the register layout
  localparam int OFS_WORD   = 0;
  localparam int OFS_ERRFT  = 1;
  localparam int OFS_COUNT  = 2;
  localparam int OFS_ADDR0  = 3;
  localparam int OFS_ADDR1  = 4;
  localparam int OFS_ADDR2  = 5;
  localparam int OFS_DEVH   = 6;
  localparam int OFS_STCMD  = 7;
  // control-block offset of alternate status / device control
  localparam int OFS_CTL    = 6;

  // status bit positions
  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DF   = 5;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;

  // device-control bit positions
  localparam int DC_SRST = 2;
  localparam int DC_MASK = 1;

  // device byte fields
  localparam int DV_LBA  = 6;
  localparam int DV_SEL  = 4;
  localparam logic [7:0] DV_FIXED = 8'hA0;

  typedef struct packed {
    logic bsy;
    logic drdy;
    logic df;
    logic drq;
    logic err;
  } stat_t;

  function automatic logic [7:0] pack_status(input stat_t s);
    logic [7:0] b;
    b = '0;
    b[ST_BSY]  = s.bsy;
    b[ST_DRDY] = s.drdy;
    b[ST_DF]   = s.df;
    b[ST_DRQ]  = s.drq;
    b[ST_ERR]  = s.err;
    return b;
  endfunction

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode #(
  parameter int AW = 3
) (
  input  logic [AW-1:0]      addr,
  input  logic               ctl_sel,
  input  logic               wr_en,
  input  logic               rd_en,
  output logic [(1<<AW)-1:0] cb_wr,
  output logic [(1<<AW)-1:0] cb_rd,
  output logic               ctl_wr,
  output logic               ctl_rd
);
  import ata_tf_pkg::*;

  localparam int NREG = 1 << AW;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign cb_wr[i] = wr_en & ~ctl_sel & (addr == AW'(i));
    assign cb_rd[i] = rd_en & ~ctl_sel & (addr == AW'(i));
  end

  assign ctl_wr = wr_en & ctl_sel & (addr == AW'(OFS_CTL));
  assign ctl_rd = rd_en & ctl_sel & (addr == AW'(OFS_CTL));

endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs #(
  parameter int RW    = 8,
  parameter int FIRST = 1,
  parameter int LAST  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LAST:FIRST]  pr_wr,
  input  logic               cmd_acc,
  input  logic [RW-1:0]      wdata,
  output logic [RW-1:0]      features,
  output logic [RW-1:0]      count,
  output logic [RW-1:0]      addr0,
  output logic [RW-1:0]      addr1,
  output logic [RW-1:0]      addr2,
  output logic [RW-1:0]      devh,
  output logic [RW-1:0]      cmd_code
);
  import ata_tf_pkg::*;

  logic [RW-1:0] pr_q [FIRST:LAST];
  logic [RW-1:0] pr_d [FIRST:LAST];
  logic [RW-1:0] cmd_q, cmd_d;

  for (genvar i = FIRST; i <= LAST; i++) begin : g_pr
    always_comb begin
      pr_d[i] = pr_q[i];
      if (pr_wr[i]) pr_d[i] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pr_q[i] <= '0;
      else        pr_q[i] <= pr_d[i];
    end
  end

  always_comb begin
    cmd_d = cmd_q;
    if (cmd_acc) cmd_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  assign features = pr_q[OFS_ERRFT];
  assign count    = pr_q[OFS_COUNT];
  assign addr0    = pr_q[OFS_ADDR0];
  assign addr1    = pr_q[OFS_ADDR1];
  assign addr2    = pr_q[OFS_ADDR2];
  assign devh     = pr_q[OFS_DEVH];
  assign cmd_code = cmd_q;

endmodule

// File: rtl/ata_tf_status.sv
module ata_tf_status #(
  parameter int RW         = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          ctl_wr,
  input  logic          ctl_srst,
  input  logic          ctl_mask,
  input  logic          stat_rd,
  input  logic          eng_done,
  input  logic          eng_drq,
  input  logic          eng_df,
  input  logic [RW-1:0] eng_err_code,
  output logic [RW-1:0] status_byte,
  output logic [RW-1:0] err_byte,
  output logic          cmd_acc,
  output logic          cmd_strobe,
  output logic          intrq,
  output logic          bsy,
  output logic          pend,
  output logic          srst,
  output logic          mask
);
  import ata_tf_pkg::*;

  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  stat_t         st_q, st_d;
  logic [RW-1:0] ecode_q, ecode_d;
  logic          pend_q, pend_d;
  logic          srst_q, srst_d;
  logic          mask_q, mask_d;
  logic          strb_q, strb_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign cmd_acc = cmd_wr & ~st_q.bsy & ~srst_q;

  always_comb begin
    st_d    = st_q;
    ecode_d = ecode_q;
    pend_d  = pend_q;
    srst_d  = srst_q;
    mask_d  = mask_q;
    cnt_d   = cnt_q;
    strb_d  = 1'b0;

    if (ctl_wr) mask_d = ctl_mask;

    if (ctl_wr && ctl_srst) begin
      srst_d  = 1'b1;
      st_d    = '{bsy: 1'b1, drdy: 1'b0, df: 1'b0, drq: 1'b0, err: 1'b0};
      ecode_d = '0;
      pend_d  = 1'b0;
      cnt_d   = '0;
    end else if (srst_q) begin
      if (ctl_wr) begin
        srst_d = 1'b0;
        cnt_d  = CNT_LOAD;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) begin
        st_d.bsy  = 1'b0;
        st_d.drdy = 1'b1;
      end
    end else if (cmd_acc) begin
      st_d.bsy = 1'b1;
      st_d.drq = 1'b0;
      st_d.df  = 1'b0;
      st_d.err = 1'b0;
      ecode_d  = '0;
      pend_d   = 1'b0;
      strb_d   = 1'b1;
    end else if (eng_done && st_q.bsy) begin
      st_d.bsy = 1'b0;
      st_d.drq = eng_drq;
      st_d.df  = eng_df;
      st_d.err = |eng_err_code;
      ecode_d  = eng_err_code;
      pend_d   = 1'b1;
    end else if (stat_rd) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '{bsy: 1'b0, drdy: 1'b1, df: 1'b0, drq: 1'b0, err: 1'b0};
      ecode_q <= '0;
      pend_q  <= 1'b0;
      srst_q  <= 1'b0;
      mask_q  <= 1'b0;
      strb_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      st_q    <= st_d;
      ecode_q <= ecode_d;
      pend_q  <= pend_d;
      srst_q  <= srst_d;
      mask_q  <= mask_d;
      strb_q  <= strb_d;
      cnt_q   <= cnt_d;
    end
  end

  assign status_byte = pack_status(st_q);
  assign err_byte    = ecode_q;
  assign cmd_strobe  = strb_q;
  assign intrq       = pend_q & ~mask_q;
  assign bsy         = st_q.bsy;
  assign pend        = pend_q;
  assign srst        = srst_q;
  assign mask        = mask_q;

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile #(
  parameter int ADDR_W     = 3,
  parameter int REG_W      = 8,
  parameter int WORD_W     = 16,
  parameter int RST_CYCLES = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic                 host_ctl_sel,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [REG_W-1:0]     host_wdata,
  input  logic [WORD_W-1:0]    host_wword,
  output logic [REG_W-1:0]     host_rdata,
  output logic [WORD_W-1:0]    host_rword,
  output logic                 intrq,
  output logic                 cmd_strobe,
  output logic [REG_W-1:0]     cmd_code,
  output logic [REG_W-1:0]     tf_features,
  output logic [REG_W-1:0]     tf_count,
  output logic [3*REG_W+3:0]   tf_lba,
  output logic                 tf_lba_mode,
  output logic                 tf_dev_sel,
  output logic                 word_push,
  output logic [WORD_W-1:0]    word_out,
  output logic                 word_pop,
  input  logic [WORD_W-1:0]    word_in,
  input  logic                 eng_done,
  input  logic                 eng_drq,
  input  logic                 eng_df,
  input  logic [REG_W-1:0]     eng_err_code
);
  import ata_tf_pkg::*;

  localparam int NREG = 1 << ADDR_W;

  // reset: asserted asynchronously, released through a short flop chain
  logic [SYNC_DEPTH-1:0] rst_pipe;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_DEPTH-1];

  logic [NREG-1:0] cb_wr, cb_rd;
  logic            ctl_wr, ctl_rd;

  ata_tf_decode #(.AW(ADDR_W)) u_dec (
    .addr    (host_addr),
    .ctl_sel (host_ctl_sel),
    .wr_en   (host_wr),
    .rd_en   (host_rd),
    .cb_wr   (cb_wr),
    .cb_rd   (cb_rd),
    .ctl_wr  (ctl_wr),
    .ctl_rd  (ctl_rd)
  );

  logic             cmd_acc;
  logic [REG_W-1:0] r_feat, r_cnt, r_a0, r_a1, r_a2, r_dev;

  ata_tf_regs #(.RW(REG_W), .FIRST(OFS_ERRFT), .LAST(OFS_DEVH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .pr_wr    (cb_wr[OFS_DEVH:OFS_ERRFT]),
    .cmd_acc  (cmd_acc),
    .wdata    (host_wdata),
    .features (r_feat),
    .count    (r_cnt),
    .addr0    (r_a0),
    .addr1    (r_a1),
    .addr2    (r_a2),
    .devh     (r_dev),
    .cmd_code (cmd_code)
  );

  logic [REG_W-1:0] status_byte, err_byte;
  logic             st_bsy, st_pend, st_srst, st_mask;

  ata_tf_status #(.RW(REG_W), .RST_CYCLES(RST_CYCLES)) u_stat (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .cmd_wr       (cb_wr[OFS_STCMD]),
    .ctl_wr       (ctl_wr),
    .ctl_srst     (host_wdata[DC_SRST]),
    .ctl_mask     (host_wdata[DC_MASK]),
    .stat_rd      (cb_rd[OFS_STCMD]),
    .eng_done     (eng_done),
    .eng_drq      (eng_drq),
    .eng_df       (eng_df),
    .eng_err_code (eng_err_code),
    .status_byte  (status_byte),
    .err_byte     (err_byte),
    .cmd_acc      (cmd_acc),
    .cmd_strobe   (cmd_strobe),
    .intrq        (intrq),
    .bsy          (st_bsy),
    .pend         (st_pend),
    .srst         (st_srst),
    .mask         (st_mask)
  );

  // registered read-back
  logic [REG_W-1:0]  rdata_q, rdata_d;
  logic [WORD_W-1:0] rword_q, rword_d;

  always_comb begin
    rdata_d = rdata_q;
    if (ctl_rd) begin
      rdata_d = status_byte;
    end else if (host_rd) begin
      rdata_d = '0;
      if (!host_ctl_sel) begin
        case (int'(host_addr))
          OFS_ERRFT: rdata_d = err_byte;
          OFS_COUNT: rdata_d = r_cnt;
          OFS_ADDR0: rdata_d = r_a0;
          OFS_ADDR1: rdata_d = r_a1;
          OFS_ADDR2: rdata_d = r_a2;
          OFS_DEVH:  rdata_d = r_dev | DV_FIXED;
          OFS_STCMD: rdata_d = status_byte;
          default:   rdata_d = '0;
        endcase
      end
    end
  end

  always_comb begin
    rword_d = rword_q;
    if (cb_rd[OFS_WORD]) rword_d = word_in;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rdata_q <= '0;
      rword_q <= '0;
    end else begin
      rdata_q <= rdata_d;
      rword_q <= rword_d;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rword  = rword_q;
  assign tf_features = r_feat;
  assign tf_count    = r_cnt;
  assign tf_lba      = {r_dev[3:0], r_a2, r_a1, r_a0};
  assign tf_lba_mode = r_dev[DV_LBA];
  assign tf_dev_sel  = r_dev[DV_SEL];
  assign word_push   = cb_wr[OFS_WORD];
  assign word_out    = host_wword;
  assign word_pop    = cb_rd[OFS_WORD];

endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_strobe,
  input logic [7:0] cmd_code,
  input logic       cmd_wr,
  input logic       stat_rd,
  input logic       eng_done,
  input logic       bsy,
  input logic       pend,
  input logic       srst,
  input logic       mask,
  input logic       intrq
);

  // R5: a strobe only accompanies a busy device and lasts one cycle
  a_r5_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> bsy);
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);

  // R6: command writes while busy leave the opcode and strobe alone
  a_r6_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bsy) |=> ($stable(cmd_code) && !cmd_strobe));

  // R8: reading status acknowledges the interrupt
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !eng_done) |=> !pend);

  // R9: a masked interrupt never reaches the pin
  a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
    intrq |-> (!mask && pend));

  // R11: soft reset holds busy and no interrupt
  a_r11_srst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> (bsy && !pend));

  // R12: release of soft reset starts recovery while still busy
  a_r12_recovery_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst) |-> bsy);

endmodule

bind ata_taskfile ata_taskfile_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .cmd_strobe (cmd_strobe),
  .cmd_code   (cmd_code),
  .cmd_wr     (cb_wr[7]),
  .stat_rd    (cb_rd[7]),
  .eng_done   (eng_done),
  .bsy        (st_bsy),
  .pend       (st_pend),
  .srst       (st_srst),
  .mask       (st_mask),
  .intrq      (intrq)
);

// File: tb/ata_taskfile_test.sv
`timescale 1ns/1ps
module ata_taskfile_test;

  localparam int RSTC = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  host_addr;
  logic        host_ctl_sel, host_wr, host_rd;
  logic [7:0]  host_wdata;
  logic [15:0] host_wword;
  logic [7:0]  host_rdata;
  logic [15:0] host_rword;
  logic        intrq, cmd_strobe;
  logic [7:0]  cmd_code, tf_features, tf_count;
  logic [27:0] tf_lba;
  logic        tf_lba_mode, tf_dev_sel;
  logic        word_push, word_pop;
  logic [15:0] word_out, word_in;
  logic        eng_done, eng_drq, eng_df;
  logic [7:0]  eng_err_code;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ata_taskfile #(.RST_CYCLES(RSTC)) uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_ctl_sel(host_ctl_sel),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_wword(host_wword), .host_rdata(host_rdata), .host_rword(host_rword),
    .intrq(intrq), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
    .tf_features(tf_features), .tf_count(tf_count), .tf_lba(tf_lba),
    .tf_lba_mode(tf_lba_mode), .tf_dev_sel(tf_dev_sel), .word_push(word_push),
    .word_out(word_out), .word_pop(word_pop), .word_in(word_in),
    .eng_done(eng_done), .eng_drq(eng_drq), .eng_df(eng_df),
    .eng_err_code(eng_err_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all bus tasks start just after a falling edge
  task automatic bus_wr(input logic ctl, input logic [2:0] a, input logic [7:0] d);
    host_ctl_sel = ctl; host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_ctl_sel = 1'b0;
  endtask

  task automatic bus_rd(input logic ctl, input logic [2:0] a, output logic [7:0] d);
    host_ctl_sel = ctl; host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; host_ctl_sel = 1'b0;
    d = host_rdata;
  endtask

  task automatic eng_finish(input logic drq, input logic df, input logic [7:0] code);
    eng_done = 1'b1; eng_drq = drq; eng_df = df; eng_err_code = code;
    @(negedge clk);
    eng_done = 1'b0; eng_drq = 1'b0; eng_df = 1'b0; eng_err_code = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 intrq", 32'(intrq), 32'h0);
    chk("R1 cmd_strobe", 32'(cmd_strobe), 32'h0);
    bus_rd(1'b0, 3'd7, v); chk("R1 status", 32'(v), 32'h40);
    bus_rd(1'b0, 3'd1, v); chk("R1 error", 32'(v), 32'h00);
  endtask

  task automatic t_params();
    logic [7:0] v;
    bus_wr(1'b0, 3'd2, 8'h11);
    bus_wr(1'b0, 3'd3, 8'h22);
    bus_wr(1'b0, 3'd4, 8'h33);
    bus_wr(1'b0, 3'd5, 8'h44);
    bus_rd(1'b0, 3'd2, v); chk("R2 count", 32'(v), 32'h11);
    bus_rd(1'b0, 3'd3, v); chk("R2 addr low", 32'(v), 32'h22);
    bus_rd(1'b0, 3'd4, v); chk("R2 addr mid", 32'(v), 32'h33);
    bus_rd(1'b0, 3'd5, v); chk("R2 addr high", 32'(v), 32'h44);
    chk("R2 tf_count", 32'(tf_count), 32'h11);
  endtask

  task automatic t_device();
    logic [7:0] v;
    bus_wr(1'b0, 3'd6, 8'h00);
    bus_rd(1'b0, 3'd6, v); chk("R3 fixed bits", 32'(v), 32'hA0);
    bus_wr(1'b0, 3'd6, 8'h5E);
    bus_rd(1'b0, 3'd6, v); chk("R3 device byte", 32'(v), 32'hFE);
    chk("R3 tf_lba", 32'(tf_lba), 32'h0E443322);
    chk("R3 lba mode", 32'(tf_lba_mode), 32'h1);
    chk("R3 dev sel", 32'(tf_dev_sel), 32'h1);
  endtask

  task automatic t_features();
    logic [7:0] v;
    bus_wr(1'b0, 3'd1, 8'h5A);
    chk("R4 tf_features", 32'(tf_features), 32'h5A);
    bus_rd(1'b0, 3'd1, v); chk("R4 error read", 32'(v), 32'h00);
  endtask

  task automatic t_command();
    logic [7:0] v;
    bus_wr(1'b0, 3'd7, 8'h25);
    chk("R5 strobe", 32'(cmd_strobe), 32'h1);
    chk("R5 code", 32'(cmd_code), 32'h25);
    bus_rd(1'b0, 3'd7, v); chk("R5 busy status", 32'(v), 32'hC0);
    chk("R5 strobe single", 32'(cmd_strobe), 32'h0);
  endtask

  task automatic t_busy_ignore();
    bus_wr(1'b0, 3'd7, 8'hEC);
    chk("R6 no strobe", 32'(cmd_strobe), 32'h0);
    chk("R6 code kept", 32'(cmd_code), 32'h25);
  endtask

  task automatic t_complete();
    logic [7:0] v;
    eng_finish(1'b1, 1'b0, 8'h00);
    chk("R7 intrq", 32'(intrq), 32'h1);
    bus_rd(1'b1, 3'd6, v); chk("R8 alt status", 32'(v), 32'h48);
    chk("R8 alt keeps intrq", 32'(intrq), 32'h1);
    bus_rd(1'b0, 3'd7, v); chk("R7 status", 32'(v), 32'h48);
    chk("R8 read clears intrq", 32'(intrq), 32'h0);
  endtask

  task automatic t_mask_error();
    logic [7:0] v;
    bus_wr(1'b1, 3'd6, 8'h02);
    bus_wr(1'b0, 3'd7, 8'hC8);
    chk("R5 second strobe", 32'(cmd_strobe), 32'h1);
    eng_finish(1'b0, 1'b1, 8'h04);
    chk("R9 masked", 32'(intrq), 32'h0);
    bus_wr(1'b1, 3'd6, 8'h00);
    chk("R9 unmasked", 32'(intrq), 32'h1);
    bus_rd(1'b1, 3'd6, v); chk("R10 status err df", 32'(v), 32'h61);
    bus_rd(1'b0, 3'd1, v); chk("R10 error code", 32'(v), 32'h04);
    bus_rd(1'b0, 3'd7, v);
    chk("R8 intrq after status", 32'(intrq), 32'h0);
  endtask

  task automatic t_soft_reset();
    logic [7:0] v;
    bus_wr(1'b1, 3'd6, 8'h04);
    bus_rd(1'b1, 3'd6, v); chk("R11 status in reset", 32'(v), 32'h80);
    bus_rd(1'b0, 3'd1, v); chk("R11 error cleared", 32'(v), 32'h00);
    chk("R11 intrq", 32'(intrq), 32'h0);
    bus_wr(1'b0, 3'd7, 8'h30);
    chk("R6 strobe in reset", 32'(cmd_strobe), 32'h0);
    chk("R6 code in reset", 32'(cmd_code), 32'hC8);
    bus_wr(1'b1, 3'd6, 8'h00);
    repeat (RSTC - 1) @(negedge clk);
    bus_rd(1'b1, 3'd6, v); chk("R12 still busy", 32'(v), 32'h80);
    bus_rd(1'b1, 3'd6, v); chk("R12 ready", 32'(v), 32'h40);
    bus_wr(1'b0, 3'd7, 8'h24);
    chk("R12 command accepted", 32'(cmd_strobe), 32'h1);
    eng_finish(1'b0, 1'b0, 8'h00);
    bus_rd(1'b0, 3'd7, v);
  endtask

  task automatic t_words();
    word_in = 16'h1234;
    host_ctl_sel = 1'b0; host_addr = 3'd0; host_wword = 16'hBEEF; host_wr = 1'b1;
    #1;
    chk("R13 push", 32'(word_push), 32'h1);
    chk("R13 word out", 32'(word_out), 32'hBEEF);
    @(negedge clk);
    host_wr = 1'b0;
    host_rd = 1'b1;
    #1;
    chk("R13 pop", 32'(word_pop), 32'h1);
    @(negedge clk);
    host_rd = 1'b0;
    chk("R13 word read", 32'(host_rword), 32'h1234);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    host_addr = '0; host_ctl_sel = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = '0; host_wword = '0; word_in = '0;
    eng_done = 1'b0; eng_drq = 1'b0; eng_df = 1'b0; eng_err_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_params();
    t_device();
    t_features();
    t_command();
    t_busy_ignore();
    t_complete();
    t_mask_error();
    t_soft_reset();
    t_words();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule